// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Access Checks

This block is a small, fully associative cache of virtual-to-physical page translations. Each entry holds a virtual page number, the address-space identifier of the process that owns the mapping, a physical frame number, permission bits for writing and executing, a Global flag, and accessed and dirty status bits. Every cycle it can take one lookup made of a virtual address, the current address-space identifier and an access kind. One cycle later it returns a registered result: whether a usable translation was found, the physical address, and whether the access broke the entry's permissions.

A page walker outside the block loads translations through a fill port. The block picks the slot itself: a slot already holding the same page, otherwise the lowest empty slot, otherwise a round-robin victim. Software-driven maintenance uses an invalidate port. It can clear every entry, clear every non-Global entry of one identifier, or clear one page. Alongside each successful result the block raises one-cycle events when an entry is used for the first time or written for the first time, so that the status bits can be copied back to the page table.

Top module: `asid_xlat_cache`

## Requirements
- R1: Only the virtual page number (address bits 31..12) is compared. Lookups to any offset within a cached page hit the same entry.
- R2: On a successful lookup `rs_pa` equals the stored frame number in bits 31..12 with lookup address bits 11..0 copied unchanged below it. A frame number of zero gives a physical address equal to the offset. On any other result `rs_pa` is zero.
- R3: A non-Global entry matches only when its identifier equals `lk_asid`. A Global entry matches under every identifier. A lookup with no matching entry returns `rs_hit`=0, `rs_fault`=0 and no events.
- R4: `inv_op`=2 clears every non-Global entry whose identifier equals `inv_asid`. Global entries and entries of other identifiers remain usable.
- R5: `inv_op`=1 clears all entries. `inv_op`=3 clears the entries for page `inv_vpn` that are Global or tagged with `inv_asid`, and leaves other pages in place.
- R6: Access kind `lk_kind` is 0 for read, 1 for write and 2 for fetch (3 acts as read). Reads are always permitted on a match. A write to an entry without write permission, or a fetch from an entry without execute permission, gives `rs_fault`=1 with `rs_hit`=0.
- R7: The first permitted access through an entry whose accessed bit is clear raises `rs_set_accessed`. The first permitted write through an entry whose dirty bit is clear raises `rs_set_dirty`. Later hits, faults, misses and entries filled with these bits already set raise neither event.
- R8: Two different pages that map to the same frame occupy separate entries. The same page under two identifiers coexists as two entries with their own frames.
- R9: A fill with no matching entry goes to the lowest-numbered empty slot. When all slots are valid it evicts the slot at a round-robin pointer. The pointer starts at slot 0 after reset and advances only on such evictions.
- R10: A fill whose page and identifier match a valid entry (by the R3 rule) overwrites that entry, so a lookup never matches more than one entry.
- R11: A lookup presented in one cycle is answered in the next cycle with `rs_valid`=1. Without a lookup, `rs_valid`, `rs_hit` and `rs_fault` are 0.
- R12: When `inv_op` is nonzero in the same cycle as `fl_valid`, the invalidate is applied and the fill is dropped.
- R13: After reset no entry is valid and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fl_valid | input | 1 | Load a translation this cycle |
| fl_vpn | input | 20 | Virtual page number of the fill |
| fl_asid | input | 8 | Identifier of the fill |
| fl_pfn | input | 20 | Frame number of the fill |
| fl_global | input | 1 | Fill is shared by all identifiers |
| fl_write_ok | input | 1 | Fill permits writes |
| fl_exec_ok | input | 1 | Fill permits fetches |
| fl_accessed | input | 1 | Initial accessed bit |
| fl_dirty | input | 1 | Initial dirty bit |
| inv_op | input | 2 | 0 none, 1 all, 2 by identifier, 3 by page |
| inv_asid | input | 8 | Identifier for invalidates by identifier or page |
| inv_vpn | input | 20 | Page for invalidate by page |
| rs_valid | output | 1 | Result corresponds to last cycle's lookup |
| rs_hit | output | 1 | Permitted translation found |
| rs_fault | output | 1 | Matching entry refused the access |
| rs_pa | output | 32 | Physical address on a hit, else zero |
| rs_set_accessed | output | 1 | First use of the entry |
| rs_set_dirty | output | 1 | First write through the entry |

## Verification
The main sweep loads eight pages whose permission bits walk through all four write/execute combinations. It probes each page at several offsets with reads, repeated writes and fetches. This separates offset pass-through from tag compare and permitted hits from faults, and the event pattern shows first use apart from repeat use. A second pattern loads an aliased pair, the same page under two identifiers and a Global page. It then looks them up under matching and foreign identifiers before and after each kind of invalidate, which tells identifier matching apart from the Global bypass. A last pattern fills past capacity with page invalidates in between, so that empty-slot reuse and round-robin eviction show up as different surviving pages.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } access_kind_e;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_ASID = 2'd2,
    INV_PAGE = 2'd3
  } inv_kind_e;
endpackage

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             ent_valid,
  input  logic [N-1:0]             ent_global,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][ASID_W-1:0] ent_asid,
  input  logic [VPN_W-1:0]         q_vpn,
  input  logic [ASID_W-1:0]        q_asid,
  output logic [N-1:0]             match
);
  // one comparator per slot; Global bypasses the identifier compare
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_vpn[i] == q_vpn) &&
                      (ent_global[i] || (ent_asid[i] == q_asid));
  end
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     ent_valid,
  input  logic             alloc,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    idx = any_free ? free_idx : rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc && !any_free) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_PICK_EMPTY_SLOT: assert property (@(posedge clk) disable iff (rst)
    (alloc && !(&ent_valid)) |-> !ent_valid[idx]);  // R9
  AST_POINTER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(alloc) |-> $stable(rr_q));  // R9
endmodule

// File: rtl/asid_xlat_cache.sv
module asid_xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_va,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [1:0]             lk_kind,
  input  logic                   fl_valid,
  input  logic [VA_W-OFF_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0]      fl_asid,
  input  logic [PFN_W-1:0]       fl_pfn,
  input  logic                   fl_global,
  input  logic                   fl_write_ok,
  input  logic                   fl_exec_ok,
  input  logic                   fl_accessed,
  input  logic                   fl_dirty,
  input  logic [1:0]             inv_op,
  input  logic [ASID_W-1:0]      inv_asid,
  input  logic [VA_W-OFF_W-1:0]  inv_vpn,
  output logic                   rs_valid,
  output logic                   rs_hit,
  output logic                   rs_fault,
  output logic [PFN_W+OFF_W-1:0] rs_pa,
  output logic                   rs_set_accessed,
  output logic                   rs_set_dirty
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry storage
  logic [ENTRIES-1:0]             e_valid, e_glob, e_wr, e_x, e_acc, e_dirty;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid;
  logic [ENTRIES-1:0][PFN_W-1:0]  e_pfn;

  logic [ENTRIES-1:0] lk_match, fl_match, inv_hit;
  logic [IDX_W-1:0]   lk_idx, fl_hit_idx, victim_idx, fill_idx;
  logic               lk_any, perm_ok, grant, fill_go, fill_new;
  access_kind_e       kind;
  inv_kind_e          iop;

  assign kind = access_kind_e'(lk_kind);
  assign iop  = inv_kind_e'(inv_op);

  xlat_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .ent_valid(e_valid), .ent_global(e_glob), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .q_vpn(lk_va[VA_W-1:OFF_W]), .q_asid(lk_asid), .match(lk_match)
  );

  xlat_tag_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_match (
    .ent_valid(e_valid), .ent_global(e_glob), .ent_vpn(e_vpn), .ent_asid(e_asid),
    .q_vpn(fl_vpn), .q_asid(fl_asid), .match(fl_match)
  );

  xlat_victim_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .ent_valid(e_valid), .alloc(fill_new), .idx(victim_idx)
  );

  always_comb begin
    lk_idx     = '0;
    fl_hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
      if (fl_match[i]) fl_hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    lk_any = |lk_match;
    unique case (kind)
      KIND_WRITE: perm_ok = e_wr[lk_idx];
      KIND_FETCH: perm_ok = e_x[lk_idx];
      default:    perm_ok = 1'b1;
    endcase
    grant    = lk_valid && lk_any && perm_ok;
    fill_go  = fl_valid && (iop == INV_NONE);
    fill_new = fill_go && !(|fl_match);
    fill_idx = (|fl_match) ? fl_hit_idx : victim_idx;
  end

  // which slots the maintenance operation removes
  for (genvar i = 0; i < ENTRIES; i++) begin : g_inv
    always_comb begin
      unique case (iop)
        INV_ALL:  inv_hit[i] = 1'b1;
        INV_ASID: inv_hit[i] = !e_glob[i] && (e_asid[i] == inv_asid);
        INV_PAGE: inv_hit[i] = (e_vpn[i] == inv_vpn) &&
                               (e_glob[i] || (e_asid[i] == inv_asid));
        default:  inv_hit[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        e_valid[i] <= 1'b0;
      end else if (inv_hit[i]) begin
        e_valid[i] <= 1'b0;
      end else if (fill_go && (fill_idx == IDX_W'(i))) begin
        e_valid[i] <= 1'b1;
        e_vpn[i]   <= fl_vpn;
        e_asid[i]  <= fl_asid;
        e_pfn[i]   <= fl_pfn;
        e_glob[i]  <= fl_global;
        e_wr[i]    <= fl_write_ok;
        e_x[i]     <= fl_exec_ok;
        e_acc[i]   <= fl_accessed;
        e_dirty[i] <= fl_dirty;
      end else if (grant && lk_match[i]) begin
        e_acc[i] <= 1'b1;
        if (kind == KIND_WRITE) e_dirty[i] <= 1'b1;
      end
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid        <= 1'b0;
      rs_hit          <= 1'b0;
      rs_fault        <= 1'b0;
      rs_pa           <= '0;
      rs_set_accessed <= 1'b0;
      rs_set_dirty    <= 1'b0;
    end else begin
      rs_valid        <= lk_valid;
      rs_hit          <= grant;
      rs_fault        <= lk_valid && lk_any && !perm_ok;
      rs_pa           <= grant ? {e_pfn[lk_idx], lk_va[OFF_W-1:0]} : '0;
      rs_set_accessed <= grant && !e_acc[lk_idx];
      rs_set_dirty    <= grant && (kind == KIND_WRITE) && !e_dirty[lk_idx];
    end
  end

  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    rs_fault |-> !rs_hit);  // R6
  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    rs_hit |-> (rs_pa[OFF_W-1:0] == $past(lk_va[OFF_W-1:0])));  // R2
  AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    rs_set_dirty |-> (rs_hit && ($past(lk_kind) == 2'd1)));  // R7
  AST_EVENT_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    rs_set_accessed |-> rs_hit);  // R7
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> ($countones(lk_match) <= 1));  // R10
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);  // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rs_valid && !rs_hit && !rs_fault));  // R11
endmodule

// File: tb/sim_asid_xlat_cache.sv
module sim_asid_xlat_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic [1:0]  lk_kind = '0;
  logic        fl_valid = 1'b0;
  logic [19:0] fl_vpn = '0;
  logic [7:0]  fl_asid = '0;
  logic [19:0] fl_pfn = '0;
  logic        fl_global = 1'b0, fl_write_ok = 1'b0, fl_exec_ok = 1'b0;
  logic        fl_accessed = 1'b0, fl_dirty = 1'b0;
  logic [1:0]  inv_op = '0;
  logic [7:0]  inv_asid = '0;
  logic [19:0] inv_vpn = '0;
  logic        rs_valid, rs_hit, rs_fault, rs_set_accessed, rs_set_dirty;
  logic [31:0] rs_pa;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  asid_xlat_cache u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_kind(lk_kind), .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
    .fl_pfn(fl_pfn), .fl_global(fl_global), .fl_write_ok(fl_write_ok),
    .fl_exec_ok(fl_exec_ok), .fl_accessed(fl_accessed), .fl_dirty(fl_dirty),
    .inv_op(inv_op), .inv_asid(inv_asid), .inv_vpn(inv_vpn), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_fault(rs_fault), .rs_pa(rs_pa),
    .rs_set_accessed(rs_set_accessed), .rs_set_dirty(rs_set_dirty)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                      input logic [19:0] pfn, input logic g, w, x, a, d);
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = vpn; fl_asid = asid; fl_pfn = pfn;
    fl_global = g; fl_write_ok = w; fl_exec_ok = x; fl_accessed = a; fl_dirty = d;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic inval(input logic [1:0] op, input logic [7:0] asid,
                       input logic [19:0] vpn);
    @(negedge clk);
    inv_op = op; inv_asid = asid; inv_vpn = vpn;
    @(negedge clk);
    inv_op = 2'd0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic [1:0] kind, input logic eh, ef,
                      input logic [31:0] epa, input logic ea, ed, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_kind = kind;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "valid", 32'(rs_valid), 32'd1);
    chk(req, "hit", 32'(rs_hit), 32'(eh));
    chk(req, "fault", 32'(rs_fault), 32'(ef));
    chk(req, "pa", rs_pa, epa);
    chk(req, "accessed_ev", 32'(rs_set_accessed), 32'(ea));
    chk(req, "dirty_ev", 32'(rs_set_dirty), 32'(ed));
  endtask

  function automatic logic [11:0] probe_off(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'h01F;
      2: return 12'hFFF;
      default: return 12'h800;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13: reset state at the outputs
    chk("R13", "valid", 32'(rs_valid), 32'd0);
    chk("R13", "hit", 32'(rs_hit), 32'd0);
    chk("R13", "pa", rs_pa, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "idle valid", 32'(rs_valid), 32'd0);
    for (int v = 0; v < 4; v++)
      look({20'h100 + 20'(v), 12'h0}, 8'd3, 2'd0, 0, 0, 32'd0, 0, 0, "R13");

    // sweep: 8 pages, perms walk all write/exec combinations, pfn 0 on slot 0
    for (int i = 0; i < 8; i++)
      fill(20'h100 + 20'(i), 8'd3, 20'(i * 'h111), 0, i[0], i[1], 0, 0);
    for (int i = 0; i < 8; i++) begin
      logic [19:0] pf;
      logic        w, x;
      pf = 20'(i * 'h111);
      w  = i[0];
      x  = i[1];
      for (int k = 0; k < 4; k++)  // R1 R2: offsets pass through, first use once
        look({20'h100 + 20'(i), probe_off(k)}, 8'd3, 2'd0, 1, 0,
             {pf, probe_off(k)}, k == 0, 0, "R1");
      // R6 R7: writes
      look({20'h100 + 20'(i), 12'h123}, 8'd3, 2'd1, w, !w,
           w ? {pf, 12'h123} : 32'd0, 0, w, "R6");
      look({20'h100 + 20'(i), 12'h124}, 8'd3, 2'd1, w, !w,
           w ? {pf, 12'h124} : 32'd0, 0, 0, "R7");
      // R6: fetch, and kind 3 acts as read
      look({20'h100 + 20'(i), 12'h040}, 8'd3, 2'd2, x, !x,
           x ? {pf, 12'h040} : 32'd0, 0, 0, "R6");
      look({20'h100 + 20'(i), 12'h044}, 8'd3, 2'd3, 1, 0, {pf, 12'h044}, 0, 0, "R6");
      // R3: foreign identifier misses
      look({20'h100 + 20'(i), 12'h0}, 8'd4, 2'd0, 0, 0, 32'd0, 0, 0, "R3");
    end
    // R2: frame zero gives the offset alone
    look({20'h100, 12'h01F}, 8'd3, 2'd0, 1, 0, 32'h0000_001F, 0, 0, "R2");

    // R5: clear everything
    inval(2'd1, 8'd0, 20'd0);
    for (int i = 0; i < 8; i++)
      look({20'h100 + 20'(i), 12'h0}, 8'd3, 2'd0, 0, 0, 32'd0, 0, 0, "R5");

    // R8 R3: aliases, same page two identifiers, a Global page
    fill(20'h200, 8'd1, 20'h00055, 0, 1, 1, 1, 0);
    fill(20'h201, 8'd1, 20'h00055, 0, 1, 1, 1, 0);
    fill(20'h200, 8'd2, 20'h00077, 0, 1, 1, 1, 0);
    fill(20'h300, 8'd9, 20'h00099, 1, 1, 1, 1, 1);
    look({20'h200, 12'h010}, 8'd1, 2'd0, 1, 0, {20'h00055, 12'h010}, 0, 0, "R8");
    look({20'h201, 12'h010}, 8'd1, 2'd0, 1, 0, {20'h00055, 12'h010}, 0, 0, "R8");
    look({20'h200, 12'h010}, 8'd2, 2'd0, 1, 0, {20'h00077, 12'h010}, 0, 0, "R8");
    look({20'h201, 12'h010}, 8'd2, 2'd0, 0, 0, 32'd0, 0, 0, "R3");
    for (int a = 0; a < 4; a++)
      look({20'h300, 12'h0AB}, 8'(a * 85), 2'd1, 1, 0, {20'h00099, 12'h0AB}, 0, 0, "R3");
    // R4: identifier flush keeps Global and other identifiers
    inval(2'd2, 8'd1, 20'd0);
    look({20'h200, 12'h0}, 8'd1, 2'd0, 0, 0, 32'd0, 0, 0, "R4");
    look({20'h201, 12'h0}, 8'd1, 2'd0, 0, 0, 32'd0, 0, 0, "R4");
    look({20'h200, 12'h0}, 8'd2, 2'd0, 1, 0, {20'h00077, 12'h0}, 0, 0, "R4");
    look({20'h300, 12'h0}, 8'd1, 2'd0, 1, 0, {20'h00099, 12'h0}, 0, 0, "R4");
    // R5: page invalidate
    inval(2'd3, 8'd2, 20'h200);
    look({20'h200, 12'h0}, 8'd2, 2'd0, 0, 0, 32'd0, 0, 0, "R5");
    look({20'h300, 12'h0}, 8'd2, 2'd0, 1, 0, {20'h00099, 12'h0}, 0, 0, "R5");

    // R10: refill over the Global page replaces it
    fill(20'h300, 8'd5, 20'h00033, 1, 0, 0, 1, 1);
    look({20'h300, 12'h001}, 8'd7, 2'd0, 1, 0, {20'h00033, 12'h001}, 0, 0, "R10");
    look({20'h300, 12'h001}, 8'd7, 2'd1, 0, 1, 32'd0, 0, 0, "R10");

    // R12: invalidate wins over a fill in the same cycle
    @(negedge clk);
    fl_valid = 1'b1; fl_vpn = 20'h777; fl_asid = 8'd1; fl_pfn = 20'h00777;
    fl_global = 1'b0; fl_write_ok = 1'b1; fl_exec_ok = 1'b1;
    fl_accessed = 1'b1; fl_dirty = 1'b1; inv_op = 2'd1;
    @(negedge clk);
    fl_valid = 1'b0; inv_op = 2'd0;
    look({20'h777, 12'h0}, 8'd1, 2'd0, 0, 0, 32'd0, 0, 0, "R12");
    look({20'h300, 12'h0}, 8'd7, 2'd0, 0, 0, 32'd0, 0, 0, "R12");

    // R9: fill order, round-robin eviction, empty slot preferred
    for (int i = 0; i < 8; i++)
      fill(20'h400 + 20'(i), 8'd6, 20'h400 + 20'(i), 0, 1, 1, 1, 1);
    fill(20'h480, 8'd6, 20'h00480, 0, 1, 1, 1, 1);
    look({20'h400, 12'h0}, 8'd6, 2'd0, 0, 0, 32'd0, 0, 0, "R9");
    look({20'h401, 12'h0}, 8'd6, 2'd0, 1, 0, {20'h00401, 12'h0}, 0, 0, "R9");
    look({20'h480, 12'h0}, 8'd6, 2'd0, 1, 0, {20'h00480, 12'h0}, 0, 0, "R9");
    fill(20'h481, 8'd6, 20'h00481, 0, 1, 1, 1, 1);
    look({20'h401, 12'h0}, 8'd6, 2'd0, 0, 0, 32'd0, 0, 0, "R9");
    inval(2'd3, 8'd6, 20'h405);
    fill(20'h482, 8'd6, 20'h00482, 0, 1, 1, 1, 1);
    look({20'h402, 12'h0}, 8'd6, 2'd0, 1, 0, {20'h00402, 12'h0}, 0, 0, "R9");
    look({20'h482, 12'h0}, 8'd6, 2'd0, 1, 0, {20'h00482, 12'h0}, 0, 0, "R9");
    look({20'h405, 12'h0}, 8'd6, 2'd0, 0, 0, 32'd0, 0, 0, "R5");
    fill(20'h483, 8'd6, 20'h00483, 0, 1, 1, 1, 1);
    look({20'h402, 12'h0}, 8'd6, 2'd0, 0, 0, 32'd0, 0, 0, "R9");
    look({20'h403, 12'h0}, 8'd6, 2'd0, 1, 0, {20'h00403, 12'h0}, 0, 0, "R9");
    @(negedge clk);
    chk("R11", "idle valid", 32'(rs_valid), 32'd0);
    finish_run();
  end
endmodule